// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block models the device side of a three-wire serial EEPROM that stores 64 words of 16 bits. It runs on a fast system clock. It samples the host's chip select, shift clock and serial data input, and it drives a serial data output together with a separate output-enable that stands for the pin's tristate control. The host frames each command between chip select edges. A start bit of 1 opens the command, a 2-bit opcode and a 6-bit address field follow, and write data comes after them where the command needs it.

Programming commands are gated by a write-enable latch. The latch is cleared by reset and changed only by the enable and disable commands. The self-timed programming delay is replaced by a counter of `PROG_CYCLES` system clocks. While that counter runs, the host can lower chip select and raise it again to watch a ready/busy level on the data output.

The controller is a single state machine with these states:
- `ST_IDLE`: chip select is low and the output is off. A chip-select rise goes to `ST_STATUS` if programming is busy, and to `ST_WAIT_SB` otherwise.
- `ST_WAIT_SB`: zeros are skipped, and a sampled 1 goes to `ST_HEADER`.
- `ST_HEADER`: shifts in the 8 opcode/address bits, then dispatches to `ST_READ`, to `ST_DATA`, or to `ST_HOLD`.
- `ST_DATA`: shifts in 16 data bits, then starts programming and goes to `ST_HOLD`.
- `ST_READ`: shifts out the dummy bit and the data word, then goes to `ST_HOLD`.
- `ST_STATUS`: shows ready/busy on the output.
- `ST_HOLD`: ignores input until chip select falls.

A low chip select returns every state to `ST_IDLE`.

Top module: `mw_eeprom_model`

## Requirements
- R1: A command starts after a rising chip select. Leading 0 bits are skipped. A 1 is the start bit, and it is followed by a 2-bit opcode and a 6-bit address. All bits are sent MSB first and sampled on rising shift-clock edges.
- R2: The opcode encoding is 10 for read, 01 for write and 11 for erase. Opcode 00 selects a special command from address bits [5:4]: 11 sets the write-enable latch, 00 clears it, 10 erases the whole array and 01 writes the whole array. Address bits [3:0] are ignored for special commands.
- R3: After the last address bit of a read, the output is enabled and shows a 0 dummy bit. The next 16 rising shift-clock edges each present the next data bit, MSB first. The output does not change between edges.
- R4: After reset, the output enable is low, the write-enable latch is clear and every word holds 0xFFFF.
- R5: The write-enable latch stays set across any number of commands until a disable command or a reset. Read works whether the latch is set or clear.
- R6: A write stores the 16 data bits that follow the address. Programming starts in the cycle after the last data bit is sampled. No erase is needed first.
- R7: An erase sets only the addressed word to 0xFFFF. Erase-all sets every word to 0xFFFF.
- R8: Write-all loads the same 16-bit value into every word.
- R9: A programming command issued while the latch is clear leaves memory unchanged and starts no busy period.
- R10: If chip select is raised while programming runs, the output is enabled and reads 0 until `PROG_CYCLES` clocks after the start, and 1 after that. Whenever chip select is low, the output enable is low.
- R11: If chip select is raised after the programming period has ended, no status is shown and the output enable stays low.
- R12: If chip select falls before a command is complete, the command is abandoned with no change to memory and no busy period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the shift clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select from the host, asynchronous |
| sk_i | input | 1 | Shift clock from the host, asynchronous |
| di_i | input | 1 | Serial data from the host |
| do_o | output | 1 | Serial data or ready/busy level; 0 when not enabled |
| do_oe_o | output | 1 | Output enable for the data-out pad (1 = driven) |

## Verification
Two functions can fall in the same cycle: the programming counter running out, and the status display that is already showing busy on the output. The bench raises chip select shortly after a write has finished. It holds chip select high past the end of the programming period, with no further toggle. It judges the result by seeing 0 early in that window and 1 at its end. A second case raises chip select only after the counter has expired, and expects no status at all.

// File: rtl/mw_pkg.sv
package mw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_SB,
        ST_HEADER,
        ST_DATA,
        ST_READ,
        ST_STATUS,
        ST_HOLD
    } mw_state_e;

    localparam logic [1:0] OP_SPECIAL = 2'b00;
    localparam logic [1:0] OP_WRITE   = 2'b01;
    localparam logic [1:0] OP_READ    = 2'b10;
    localparam logic [1:0] OP_ERASE   = 2'b11;

    localparam logic [1:0] SP_LOCK    = 2'b00;
    localparam logic [1:0] SP_FILL    = 2'b01;
    localparam logic [1:0] SP_WIPE    = 2'b10;
    localparam logic [1:0] SP_UNLOCK  = 2'b11;

endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q, stab_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= d_i[i];
                stab_q <= meta_q;
            end
        end
        assign q_o[i] = stab_q;
    end

endmodule

// File: rtl/mw_store.sv
module mw_store #(
    parameter int WORDS = 64,
    parameter int DW    = 16,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_one,
    input  logic          we_all,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [WORDS];

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mem[i] <= '1;
            else if (we_all || (we_one && waddr == AW'(i)))
                mem[i] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
    parameter int CYCLES = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);

    localparam int CTW = $clog2(CYCLES + 1);

    logic [CTW-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            left_q <= '0;
        else if (start_i)
            left_q <= CTW'(CYCLES);
        else if (left_q != '0)
            left_q <= left_q - 1'b1;
    end

    assign busy_o = (left_q != '0);

endmodule

// File: rtl/mw_eeprom_model.sv
module mw_eeprom_model
    import mw_pkg::*;
#(
    parameter int WORDS       = 64,
    parameter int DW          = 16,
    parameter int PROG_CYCLES = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic sk_i,
    input  logic di_i,
    output logic do_o,
    output logic do_oe_o
);

    localparam int AW = $clog2(WORDS);
    localparam int HB = 2 + AW;
    localparam int CW = $clog2(DW + 2);

    // synchronised pins and edges
    logic [2:0] sync_v;
    logic       cs_s, sk_s, di_s;
    logic       cs_d, sk_d;
    logic       cs_rise, sk_rise;

    mw_sync #(.W(3)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({cs_i, sk_i, di_i}),
        .q_o   (sync_v)
    );

    assign cs_s    = sync_v[2];
    assign sk_s    = sync_v[1];
    assign di_s    = sync_v[0];
    assign cs_rise = cs_s & ~cs_d;
    assign sk_rise = sk_s & ~sk_d;

    // state and datapath registers
    mw_state_e       state_q, state_n;
    logic [HB-1:0]   hdr_q, hdr_n, hdr_next;
    logic [CW-1:0]   cnt_q, cnt_n;
    logic [DW-1:0]   dsh_q, dsh_n, data_next;
    logic [DW:0]     rsh_q, rsh_n;
    logic            wen_q, wen_n;

    logic            prog_start, busy;
    logic            we_one, we_all;
    logic [AW-1:0]   waddr;
    logic [DW-1:0]   wdata;
    logic [DW-1:0]   rdata;
    logic            in_read;

    assign hdr_next  = {hdr_q[HB-2:0], di_s};
    assign data_next = {dsh_q[DW-2:0], di_s};

    mw_store #(.WORDS(WORDS), .DW(DW)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_one (we_one),
        .we_all (we_all),
        .waddr  (waddr),
        .wdata  (wdata),
        .raddr  (hdr_next[AW-1:0]),
        .rdata  (rdata)
    );

    mw_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (prog_start),
        .busy_o  (busy)
    );

    // next-state and datapath decisions
    always_comb begin
        state_n    = state_q;
        hdr_n      = hdr_q;
        cnt_n      = cnt_q;
        dsh_n      = dsh_q;
        rsh_n      = rsh_q;
        wen_n      = wen_q;
        prog_start = 1'b0;
        we_one     = 1'b0;
        we_all     = 1'b0;
        waddr      = hdr_q[AW-1:0];
        wdata      = '1;

        if (!cs_s) begin
            state_n = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cs_rise)
                        state_n = busy ? ST_STATUS : ST_WAIT_SB;
                end
                ST_WAIT_SB: begin
                    if (sk_rise && di_s) begin
                        state_n = ST_HEADER;
                        cnt_n   = '0;
                    end
                end
                ST_HEADER: begin
                    if (sk_rise) begin
                        hdr_n = hdr_next;
                        cnt_n = cnt_q + 1'b1;
                        if (cnt_q == CW'(HB - 1)) begin
                            cnt_n   = '0;
                            state_n = ST_HOLD;
                            unique case (hdr_next[HB-1:HB-2])
                                OP_READ: begin
                                    rsh_n   = {1'b0, rdata};
                                    state_n = ST_READ;
                                end
                                OP_WRITE: state_n = ST_DATA;
                                OP_ERASE: begin
                                    waddr = hdr_next[AW-1:0];
                                    if (wen_q) begin
                                        we_one     = 1'b1;
                                        prog_start = 1'b1;
                                    end
                                end
                                default: begin
                                    unique case (hdr_next[AW-1:AW-2])
                                        SP_UNLOCK: wen_n = 1'b1;
                                        SP_LOCK:   wen_n = 1'b0;
                                        SP_WIPE: begin
                                            if (wen_q) begin
                                                we_all     = 1'b1;
                                                prog_start = 1'b1;
                                            end
                                        end
                                        default: state_n = ST_DATA;
                                    endcase
                                end
                            endcase
                        end
                    end
                end
                ST_DATA: begin
                    if (sk_rise) begin
                        dsh_n = data_next;
                        cnt_n = cnt_q + 1'b1;
                        if (cnt_q == CW'(DW - 1)) begin
                            state_n = ST_HOLD;
                            wdata   = data_next;
                            if (wen_q) begin
                                prog_start = 1'b1;
                                if (hdr_q[HB-1:HB-2] == OP_WRITE)
                                    we_one = 1'b1;
                                else
                                    we_all = 1'b1;
                            end
                        end
                    end
                end
                ST_READ: begin
                    if (sk_rise) begin
                        rsh_n = {rsh_q[DW-1:0], 1'b0};
                        cnt_n = cnt_q + 1'b1;
                        if (cnt_q == CW'(DW))
                            state_n = ST_HOLD;
                    end
                end
                ST_STATUS: state_n = ST_STATUS;
                ST_HOLD:   state_n = ST_HOLD;
                default:   state_n = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            hdr_q   <= '0;
            cnt_q   <= '0;
            dsh_q   <= '0;
            rsh_q   <= '0;
            wen_q   <= 1'b0;
            cs_d    <= 1'b0;
            sk_d    <= 1'b0;
        end else begin
            state_q <= state_n;
            hdr_q   <= hdr_n;
            cnt_q   <= cnt_n;
            dsh_q   <= dsh_n;
            rsh_q   <= rsh_n;
            wen_q   <= wen_n;
            cs_d    <= cs_s;
            sk_d    <= sk_s;
        end
    end

    // outputs
    always_comb begin
        in_read = (state_q == ST_READ);
        do_oe_o = 1'b0;
        do_o    = 1'b0;
        unique case (state_q)
            ST_READ: begin
                do_oe_o = 1'b1;
                do_o    = rsh_q[DW];
            end
            ST_STATUS: begin
                do_oe_o = 1'b1;
                do_o    = ~busy;
            end
            default: begin
                do_oe_o = 1'b0;
                do_o    = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_s,
    input logic sk_rise,
    input logic in_read,
    input logic do_o,
    input logic do_oe_o,
    input logic prog_start,
    input logic busy,
    input logic wen_q,
    input logic we_one,
    input logic we_all
);

    // R10
    cs_low_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_s |=> !do_oe_o);

    // R3
    read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_read && cs_s && !sk_rise) |=> $stable(do_o));

    // R9
    locked_no_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> wen_q);

    // R6
    start_makes_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |=> busy);

    // R10
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> !busy);

    // R7
    single_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({we_one, we_all}));

endmodule

bind mw_eeprom_model mw_eeprom_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_s       (cs_s),
    .sk_rise    (sk_rise),
    .in_read    (in_read),
    .do_o       (do_o),
    .do_oe_o    (do_oe_o),
    .prog_start (prog_start),
    .busy       (busy),
    .wen_q      (wen_q),
    .we_one     (we_one),
    .we_all     (we_all)
);

// File: tb/sim_mw_eeprom_model.sv
`timescale 1ns/1ps
module sim_mw_eeprom_model;

    localparam int PROG = 60;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sk = 1'b0, di = 1'b0;
    logic dout, doe;

    int n_run = 0;
    int n_fail = 0;
    logic [15:0] exp_q[$];
    logic [15:0] obs_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    mw_eeprom_model #(.PROG_CYCLES(PROG)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di),
        .do_o(dout), .do_oe_o(doe)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sk_bit(input logic b);
        @(negedge clk); di = b;
        clks(3); sk = 1'b1;
        clks(6); sk = 1'b0;
        clks(3);
    endtask

    task automatic cs_up();
        @(negedge clk); cs = 1'b1;
        clks(4);
    endtask

    task automatic cs_down();
        @(negedge clk); cs = 1'b0; di = 1'b0; sk = 1'b0;
        clks(6);
    endtask

    task automatic send_hdr(input logic [1:0] op, input logic [5:0] a, input int lead);
        cs_up();
        for (int i = 0; i < lead; i++) sk_bit(1'b0);
        sk_bit(1'b1);
        for (int i = 1; i >= 0; i--) sk_bit(op[i]);
        for (int i = 5; i >= 0; i--) sk_bit(a[i]);
    endtask

    task automatic send_word(input logic [15:0] d, input int nbits);
        for (int i = 15; i > 15 - nbits; i--) sk_bit(d[i]);
    endtask

    task automatic cmd_special(input logic [5:0] a);
        send_hdr(2'b00, a, 0);
        cs_down();
    endtask

    task automatic cmd_write(input logic [5:0] a, input logic [15:0] d);
        send_hdr(2'b01, a, 0);
        send_word(d, 16);
        cs_down();
    endtask

    task automatic cmd_erase(input logic [5:0] a);
        send_hdr(2'b11, a, 0);
        cs_down();
    endtask

    task automatic cmd_fill(input logic [15:0] d);
        send_hdr(2'b00, 6'b010000, 0);
        send_word(d, 16);
        cs_down();
    endtask

    task automatic wait_prog();
        clks(PROG + 20);
    endtask

    // driver: pushes the expected word, captures the observed word
    task automatic do_read(input logic [5:0] a, input logic [15:0] exp,
                           input int lead, input string req);
        logic [15:0] got;
        exp_q.push_back(exp);
        tag_q.push_back(req);
        send_hdr(2'b10, a, lead);
        check(doe === 1'b1 && dout === 1'b0, "R3", "dummy bit and enable",
              {doe, dout}, 2'b10);
        for (int i = 15; i >= 0; i--) begin
            @(negedge clk); sk = 1'b1;
            clks(6); sk = 1'b0;
            clks(3);
            got[i] = dout;
        end
        cs_down();
        obs_q.push_back(got);
    endtask

    // monitor: compares results in order
    initial begin
        forever begin
            wait (obs_q.size() > 0);
            begin
                logic [15:0] o, e;
                string t;
                o = obs_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(o === e, t, "read word", o, e);
            end
        end
    end

    initial begin
        clks(150000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        clks(5);
        rst_n = 1'b1;
        clks(5);
        // R4 reset state
        check(doe === 1'b0, "R4", "enable after reset", doe, 0);
        do_read(6'd5, 16'hFFFF, 0, "R4");

        // R9 write while locked: no busy, no change; R5 read while locked
        cmd_write(6'd2, 16'h0000);
        cs_up();
        check(doe === 1'b0, "R9", "no busy when locked", doe, 0);
        cs_down();
        do_read(6'd2, 16'hFFFF, 0, "R9");

        // R2 unlock; R6 write; R10 status over the end of programming
        cmd_special(6'b110000);
        cmd_write(6'd3, 16'h1234);
        cs_up();
        check(doe === 1'b1 && dout === 1'b0, "R10", "busy shown", {doe, dout}, 2'b10);
        clks(PROG);
        check(doe === 1'b1 && dout === 1'b1, "R10", "ready shown", {doe, dout}, 2'b11);
        cs_down();
        check(doe === 1'b0, "R10", "off with cs low", doe, 0);
        // R1 leading zeros before the start bit
        do_read(6'd3, 16'h1234, 2, "R1");
        do_read(6'd3, 16'h1234, 0, "R6");

        cmd_write(6'd63, 16'hA5C3);
        wait_prog();
        do_read(6'd63, 16'hA5C3, 0, "R6");

        // R11 status requested too late
        cmd_write(6'd10, 16'h0F0F);
        wait_prog();
        cs_up();
        check(doe === 1'b0, "R11", "no late status", doe, 0);
        cs_down();
        do_read(6'd10, 16'h0F0F, 0, "R5");

        // R7 single erase
        cmd_erase(6'd3);
        wait_prog();
        do_read(6'd3, 16'hFFFF, 0, "R7");
        do_read(6'd63, 16'hA5C3, 0, "R7");

        // R8 whole-array write
        cmd_fill(16'h5A5A);
        wait_prog();
        do_read(6'd0, 16'h5A5A, 0, "R8");
        do_read(6'd40, 16'h5A5A, 0, "R8");

        // R7 whole-array erase
        cmd_special(6'b100000);
        wait_prog();
        do_read(6'd40, 16'hFFFF, 0, "R7");

        // R12 abort in the middle of write data
        send_hdr(2'b01, 6'd7, 0);
        send_word(16'h0000, 8);
        cs_down();
        cs_up();
        check(doe === 1'b0, "R12", "no busy after abort", doe, 0);
        cs_down();
        do_read(6'd7, 16'hFFFF, 0, "R12");

        // R5 lock again, then write has no effect
        cmd_special(6'b000000);
        cmd_write(6'd8, 16'h1111);
        wait_prog();
        do_read(6'd8, 16'hFFFF, 0, "R5");

        wait (obs_q.size() == 0);
        clks(5);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule